// File: doc/BRIEF.md
# EDID Block Fetch Sequencer

This block drives a byte-read engine on the display data channel to pull the identification data of an attached monitor into a local buffer. When started, it reads block 0 (128 bytes) as a string of short bursts. For every burst it clears the engine's receive queue, then issues a command carrying a segment number, a byte offset and a byte count. It waits for the engine's completion flag and meanwhile stores each returned byte. When a block is complete, it checks that the bytes sum to zero modulo 256.

A block that fails the sum is read again from its first byte. The extension-count field of block 0 then sets how many further blocks are fetched, with a ceiling given by a parameter. Each burst has a time limit counted in strobes of a microsecond tick. A failure on block 0 ends the fetch with an error flag. A failure on a later block only shortens the list of extensions reported as valid.

The result appears on a set of status outputs that hold until the next start. The fetched bytes can be read through a combinational read port addressed by block × 128 + byte.

Top module: `edid_fetch_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, timeout_o, csum_err_o, fifo_clear_o and cmd_valid_o are 0 and ext_count_o is 0. No command is issued while idle.
- R2: Each burst requests cmd_count_o = CHUNK (16) bytes. Within a block the burst offsets start at 0 and advance by 16, so a clean 128-byte block takes exactly 8 bursts.
- R3: Block N occupies byte addresses N×128 and up. A burst at address A drives cmd_segment_o = A >> 8 and cmd_offset_o = A mod 256, so block 2 starts at segment 1, offset 0, and block 4 at segment 2, offset 0.
- R4: fifo_clear_o is high for exactly the cycle before every cycle in which cmd_valid_o is high.
- R5: The byte returned as the k-th rx_valid_i of a burst at address A is stored at buffer address A+k. It is readable on rd_data_o at rd_addr_i = A+k.
- R6: A block whose 128 bytes do not sum to 0 modulo 256 is read again from its first byte, up to RETRIES (2) extra times. A retry that yields a good sum continues as if the block had been clean.
- R7: If block 0 still fails the sum after all tries, the fetch ends with done_o=1, csum_err_o=1, timeout_o=0 and ext_count_o=0.
- R8: If cmd_done_i has not arrived when TIMEOUT_TICKS strobes of tick_us_i have been counted since a burst was issued, the burst is abandoned. For block 0 the fetch ends with done_o=1, timeout_o=1 and ext_count_o=0. A burst that completes before the limit is unaffected.
- R9: The number of extension blocks fetched is byte 126 of block 0, capped at MAX_EXT (4). A value of 0 ends the fetch after block 0.
- R10: If an extension block fails (timeout or sum exhausted), the fetch ends at once. ext_count_o then equals the number of extension blocks already fetched, and timeout_o and csum_err_o stay 0.
- R11: busy_o is high from the cycle after an accepted start until completion. done_o, the two error flags and ext_count_o then hold until the next start_i, and that start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a fetch (accepted while idle) |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | Fetch finished; held until next start |
| timeout_o | output | 1 | Block 0 burst timed out |
| csum_err_o | output | 1 | Block 0 failed the sum on every try |
| ext_count_o | output | BLK_W | Number of valid extension blocks |
| fifo_clear_o | output | 1 | Clear the engine receive queue |
| cmd_valid_o | output | 1 | Issue a burst read command |
| cmd_segment_o | output | 8 | Segment number (address >> 8) |
| cmd_offset_o | output | 8 | Byte offset (address mod 256) |
| cmd_count_o | output | CNT_W | Bytes requested in this burst |
| cmd_done_i | input | 1 | Engine completion flag for the current burst |
| rx_valid_i | input | 1 | Returned byte strobe |
| rx_data_i | input | 8 | Returned byte |
| tick_us_i | input | 1 | Microsecond tick strobe |
| rd_addr_i | input | ADDR_W | Buffer read address |
| rd_data_o | output | 8 | Buffer read data |

## Verification
The bench goes after retries that restart mid-block rather than at offset 0. A design that got this wrong would log a retry burst at a nonzero offset and leave a bad sum. It also covers the cap on the extension count: an uncapped design would issue bursts past block 4 and report a count of 7. A timeout or sum failure on an extension block must not raise an error flag, and a design that confused the two failure paths would flag an error and report zero extensions. A slow responder that finishes just inside the tick limit catches a timer that counts clock cycles instead of tick strobes.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;

   localparam int BLOCK_BYTES   = 128;
   localparam int EXT_FIELD_IDX = 126;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_CLEAR,
      FS_ISSUE,
      FS_WAIT,
      FS_VERIFY
   } fetch_state_t;

endpackage

// File: rtl/edid_tick_timer.sv
module edid_tick_timer #(
   parameter int LIMIT = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic tick_i,
   output logic expired_o
);

   generate
      if (LIMIT == 0) begin : g_off
         logic unused_tmr;
         assign unused_tmr = ^{clk, rst_n, clear_i, tick_i};
         assign expired_o  = 1'b0;
      end else begin : g_on
         localparam int TW = $clog2(LIMIT + 1);
         logic [TW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (clear_i)
               cnt <= '0;
            else if (tick_i && (cnt != TW'(LIMIT)))
               cnt <= cnt + 1'b1;
         end

         assign expired_o = (cnt == TW'(LIMIT));
      end
   endgenerate

endmodule

// File: rtl/edid_sum8.sv
module edid_sum8 (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear_i,
   input  logic       add_i,
   input  logic [7:0] data_i,
   output logic       zero_o
);

   logic [7:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= 8'h00;
      else if (clear_i)
         acc <= 8'h00;
      else if (add_i)
         acc <= acc + data_i;
   end

   assign zero_o = (acc == 8'h00);

endmodule

// File: rtl/edid_blk_buf.sv
module edid_blk_buf #(
   parameter int DEPTH  = 640,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [7:0]        wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i)
         mem[wr_addr_i] <= wr_data_i;
   end

   assign rd_data_o = (32'(rd_addr_i) < DEPTH) ? mem[rd_addr_i] : 8'h00;

endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
   import edid_fetch_pkg::*;
#(
   parameter  int CHUNK         = 16,
   parameter  int MAX_EXT       = 4,
   parameter  int RETRIES       = 2,
   parameter  int TIMEOUT_TICKS = 200000,
   localparam int NBLK          = MAX_EXT + 1,
   localparam int DEPTH         = NBLK * BLOCK_BYTES,
   localparam int ADDR_W        = $clog2(DEPTH),
   localparam int BLK_W         = $clog2(MAX_EXT + 2),
   localparam int CNT_W         = $clog2(CHUNK + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              timeout_o,
   output logic              csum_err_o,
   output logic [BLK_W-1:0]  ext_count_o,
   output logic              fifo_clear_o,
   output logic              cmd_valid_o,
   output logic [7:0]        cmd_segment_o,
   output logic [7:0]        cmd_offset_o,
   output logic [CNT_W-1:0]  cmd_count_o,
   input  logic              cmd_done_i,
   input  logic              rx_valid_i,
   input  logic [7:0]        rx_data_i,
   input  logic              tick_us_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o
);

   localparam int TRY_W = $clog2(RETRIES + 2);
   localparam int OFS_W = $clog2(BLOCK_BYTES);
   localparam logic [OFS_W-1:0] LAST_BASE = OFS_W'(BLOCK_BYTES - CHUNK);

   // elaboration-time parameter checks
   if (CHUNK < 1 || CHUNK > BLOCK_BYTES || (BLOCK_BYTES % CHUNK) != 0) begin : g_bad_chunk
      $error("edid_fetch_seq: CHUNK must divide the block size");
   end
   if (MAX_EXT < 0 || DEPTH > 65536) begin : g_bad_ext
      $error("edid_fetch_seq: MAX_EXT out of range");
   end
   if (RETRIES < 0) begin : g_bad_retry
      $error("edid_fetch_seq: RETRIES must not be negative");
   end

   fetch_state_t     state;
   logic [BLK_W-1:0] blk;
   logic [BLK_W-1:0] ext_tgt;
   logic [BLK_W-1:0] tgt_now;
   logic [OFS_W-1:0] chunk_base;
   logic [CNT_W-1:0] wptr;
   logic [TRY_W-1:0] tries;
   logic [7:0]       ext_raw;
   logic [15:0]      base_addr;
   logic [15:0]      in_blk;
   logic             sum_zero;
   logic             expired;
   logic             wr_en;

   always_comb begin
      base_addr = 16'(blk) * 16'(BLOCK_BYTES) + 16'(chunk_base);
      in_blk    = 16'(chunk_base) + 16'(wptr);
      if (blk == '0)
         tgt_now = (ext_raw > 8'(MAX_EXT)) ? BLK_W'(MAX_EXT) : BLK_W'(ext_raw);
      else
         tgt_now = ext_tgt;
   end

   assign wr_en         = (state == FS_WAIT) && rx_valid_i && (wptr < CNT_W'(CHUNK));
   assign busy_o        = (state != FS_IDLE);
   assign fifo_clear_o  = (state == FS_CLEAR);
   assign cmd_valid_o   = (state == FS_ISSUE);
   assign cmd_segment_o = base_addr[15:8];
   assign cmd_offset_o  = base_addr[7:0];
   assign cmd_count_o   = CNT_W'(CHUNK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= FS_IDLE;
         blk         <= '0;
         ext_tgt     <= '0;
         chunk_base  <= '0;
         wptr        <= '0;
         tries       <= '0;
         ext_raw     <= 8'h00;
         done_o      <= 1'b0;
         timeout_o   <= 1'b0;
         csum_err_o  <= 1'b0;
         ext_count_o <= '0;
      end else begin
         case (state)
            FS_IDLE: begin
               if (start_i) begin
                  done_o      <= 1'b0;
                  timeout_o   <= 1'b0;
                  csum_err_o  <= 1'b0;
                  ext_count_o <= '0;
                  blk         <= '0;
                  ext_tgt     <= '0;
                  chunk_base  <= '0;
                  tries       <= '0;
                  state       <= FS_CLEAR;
               end
            end
            FS_CLEAR: state <= FS_ISSUE;
            FS_ISSUE: begin
               wptr  <= '0;
               state <= FS_WAIT;
            end
            FS_WAIT: begin
               if (wr_en) begin
                  wptr <= wptr + 1'b1;
                  if (blk == '0 && in_blk == 16'(EXT_FIELD_IDX))
                     ext_raw <= rx_data_i;
               end
               if (cmd_done_i) begin
                  if (chunk_base == LAST_BASE) begin
                     state <= FS_VERIFY;
                  end else begin
                     chunk_base <= chunk_base + OFS_W'(CHUNK);
                     state      <= FS_CLEAR;
                  end
               end else if (expired) begin
                  done_o <= 1'b0;
                  state  <= FS_IDLE;
                  done_o <= 1'b1;
                  if (blk == '0)
                     timeout_o <= 1'b1;
                  else
                     ext_count_o <= blk - 1'b1;
               end
            end
            FS_VERIFY: begin
               chunk_base <= '0;
               if (sum_zero) begin
                  if (blk == tgt_now) begin
                     ext_count_o <= blk;
                     done_o      <= 1'b1;
                     state       <= FS_IDLE;
                  end else begin
                     if (blk == '0)
                        ext_tgt <= tgt_now;
                     blk   <= blk + 1'b1;
                     tries <= '0;
                     state <= FS_CLEAR;
                  end
               end else if (tries < TRY_W'(RETRIES)) begin
                  tries <= tries + 1'b1;
                  state <= FS_CLEAR;
               end else begin
                  done_o <= 1'b1;
                  state  <= FS_IDLE;
                  if (blk == '0)
                     csum_err_o <= 1'b1;
                  else
                     ext_count_o <= blk - 1'b1;
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

   edid_tick_timer #(
      .LIMIT(TIMEOUT_TICKS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (state == FS_ISSUE),
      .tick_i   (tick_us_i && (state == FS_WAIT)),
      .expired_o(expired)
   );

   edid_sum8 u_sum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear_i((state == FS_CLEAR) && (chunk_base == '0)),
      .add_i  (wr_en),
      .data_i (rx_data_i),
      .zero_o (sum_zero)
   );

   edid_blk_buf #(
      .DEPTH (DEPTH),
      .ADDR_W(ADDR_W)
   ) u_buf (
      .clk      (clk),
      .wr_en_i  (wr_en),
      .wr_addr_i(ADDR_W'(base_addr + 16'(wptr))),
      .wr_data_i(rx_data_i),
      .rd_addr_i(rd_addr_i),
      .rd_data_o(rd_data_o)
   );

endmodule

// File: rtl/edid_fetch_seq_chk.sv
module edid_fetch_seq_chk #(
   parameter int MAX_EXT = 4,
   parameter int CHUNK   = 16,
   parameter int BLK_W   = $clog2(MAX_EXT + 2)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             timeout_o,
   input logic             csum_err_o,
   input logic [BLK_W-1:0] ext_count_o,
   input logic             fifo_clear_o,
   input logic             cmd_valid_o,
   input logic [7:0]       cmd_offset_o
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!cmd_valid_o && !fifo_clear_o));

   assert_offset_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> ((int'(cmd_offset_o) % CHUNK) == 0));

   assert_clear_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> $past(fifo_clear_o));

   assert_fail_no_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_o || csum_err_o) |-> (ext_count_o == '0));

   assert_single_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(timeout_o && csum_err_o));

   assert_ext_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_count_o <= BLK_W'(MAX_EXT));

   assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_status_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);

   assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && !done_o));

endmodule

bind edid_fetch_seq edid_fetch_seq_chk #(
   .MAX_EXT(MAX_EXT),
   .CHUNK  (CHUNK)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .timeout_o   (timeout_o),
   .csum_err_o  (csum_err_o),
   .ext_count_o (ext_count_o),
   .fifo_clear_o(fifo_clear_o),
   .cmd_valid_o (cmd_valid_o),
   .cmd_offset_o(cmd_offset_o)
);

// File: tb/edid_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module edid_fetch_seq_tb_top;

   localparam int CHUNK   = 16;
   localparam int MAX_EXT = 4;
   localparam int RETRIES = 2;
   localparam int TMO     = 30;
   localparam int ADDR_W  = 10;
   localparam int BLK_W   = 3;
   localparam int CNT_W   = 5;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              start_i;
   logic              busy_o, done_o, timeout_o, csum_err_o;
   logic [BLK_W-1:0]  ext_count_o;
   logic              fifo_clear_o, cmd_valid_o;
   logic [7:0]        cmd_segment_o, cmd_offset_o;
   logic [CNT_W-1:0]  cmd_count_o;
   logic              cmd_done_i, rx_valid_i;
   logic [7:0]        rx_data_i;
   logic              tick_us_i;
   logic [ADDR_W-1:0] rd_addr_i;
   logic [7:0]        rd_data_o;

   int nchk  = 0;
   int nfail = 0;
   bit summary_done = 0;

   // responder configuration and logs
   int ext_cfg, dly, hang_blk, burst_n, cnt_bad, clr_viol;
   int corrupt_left [5];
   int addr_log [64];
   bit clr_last = 0;
   int r_addr, r_blk, r_ib, r_n;
   bit r_bad;

   always #2.5 clk = ~clk;

   initial tick_us_i = 1'b0;
   always @(negedge clk) tick_us_i <= ~tick_us_i;

   edid_fetch_seq #(
      .CHUNK(CHUNK), .MAX_EXT(MAX_EXT), .RETRIES(RETRIES), .TIMEOUT_TICKS(TMO)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o),
      .csum_err_o(csum_err_o), .ext_count_o(ext_count_o),
      .fifo_clear_o(fifo_clear_o), .cmd_valid_o(cmd_valid_o),
      .cmd_segment_o(cmd_segment_o), .cmd_offset_o(cmd_offset_o),
      .cmd_count_o(cmd_count_o), .cmd_done_i(cmd_done_i),
      .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .tick_us_i(tick_us_i),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
   );

   function automatic int raw_byte(int b, int i);
      return (b * 37 + i * 11 + 7) % 256;
   endfunction

   function automatic int field_byte(int b);
      return (b == 0) ? ext_cfg : raw_byte(b, 126);
   endfunction

   // image byte: 0..125 pattern, 126 extension field, 127 makes the sum 0
   function automatic int img(int b, int i);
      int s;
      if (i < 126) return raw_byte(b, i);
      if (i == 126) return field_byte(b);
      s = field_byte(b);
      for (int k = 0; k < 126; k++) s += raw_byte(b, k);
      return (256 - (s % 256)) % 256;
   endfunction

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // clear-before-issue monitor
   always @(negedge clk) begin
      if (cmd_valid_o && !clr_last) clr_viol++;
      clr_last = fifo_clear_o;
   end

   // byte-read engine model
   initial begin
      rx_valid_i = 1'b0;
      rx_data_i  = 8'h00;
      cmd_done_i = 1'b0;
      forever begin
         @(negedge clk);
         if (cmd_valid_o) begin
            r_addr = int'(cmd_segment_o) * 256 + int'(cmd_offset_o);
            r_blk  = r_addr / 128;
            r_ib   = r_addr % 128;
            r_n    = int'(cmd_count_o);
            if (burst_n < 64) addr_log[burst_n] = r_addr;
            burst_n++;
            if (r_n != CHUNK) cnt_bad++;
            if (r_blk != hang_blk) begin
               r_bad = 0;
               if (r_ib == 0 && r_blk < 5 && corrupt_left[r_blk] > 0) begin
                  r_bad = 1;
                  corrupt_left[r_blk]--;
               end
               repeat (dly) @(negedge clk);
               for (int k = 0; k < r_n; k++) begin
                  rx_valid_i = 1'b1;
                  rx_data_i  = 8'(img(r_blk, r_ib + k) ^ ((r_bad && (r_ib + k) == 5) ? 1 : 0));
                  @(negedge clk);
               end
               rx_valid_i = 1'b0;
               cmd_done_i = 1'b1;
               @(negedge clk);
               cmd_done_i = 1'b0;
            end
         end
      end
   end

   task automatic prep(input int ext, input int d);
      ext_cfg  = ext;
      dly      = d;
      hang_blk = -1;
      for (int b = 0; b < 5; b++) corrupt_left[b] = 0;
      burst_n  = 0;
      cnt_bad  = 0;
      clr_viol = 0;
   endtask

   task automatic run_fetch();
      int waited;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk("R11 busy after start", int'(busy_o), 1);
      chk("R11 done cleared by start", int'(done_o), 0);
      waited = 0;
      while (!done_o && waited < 20000) begin
         @(negedge clk);
         waited++;
      end
      chk("R11 fetch completes", int'(done_o), 1);
   endtask

   task automatic t_reset();
      chk("R1 busy idle", int'(busy_o), 0);
      chk("R1 done idle", int'(done_o), 0);
      chk("R1 flags idle", int'(timeout_o) + int'(csum_err_o), 0);
      chk("R1 ext idle", int'(ext_count_o), 0);
      chk("R1 no command", int'(cmd_valid_o) + int'(fifo_clear_o), 0);
   endtask

   task automatic t_clean();
      int mis;
      prep(2, 3);
      run_fetch();
      chk("R9 ext count", int'(ext_count_o), 2);
      chk("R10 no flags", int'(timeout_o) + int'(csum_err_o), 0);
      chk("R2 burst total", burst_n, 24);
      chk("R2 burst length", cnt_bad, 0);
      chk("R4 clear before issue", clr_viol, 0);
      mis = 0;
      for (int k = 0; k < 24; k++) if (addr_log[k] != k * 16) mis++;
      chk("R2 R3 address sequence", mis, 0);
      chk("R3 block 2 start", addr_log[16], 256);
      mis = 0;
      for (int a = 0; a < 384; a++) begin
         rd_addr_i = ADDR_W'(a);
         #1;
         if (int'(rd_data_o) != img(a / 128, a % 128)) mis++;
      end
      chk("R5 buffer contents", mis, 0);
   endtask

   task automatic t_cap();
      prep(7, 1);
      run_fetch();
      chk("R9 capped ext count", int'(ext_count_o), 4);
      chk("R9 capped bursts", burst_n, 40);
      chk("R3 block 4 start segment 2", addr_log[32], 512);
      chk("R4 clear before issue cap", clr_viol, 0);
   endtask

   task automatic t_ext_zero();
      prep(0, 2);
      run_fetch();
      chk("R9 zero ext", int'(ext_count_o), 0);
      chk("R9 single block bursts", burst_n, 8);
   endtask

   task automatic t_retry_ok();
      prep(0, 2);
      corrupt_left[0] = 2;
      run_fetch();
      chk("R6 retry succeeds no flag", int'(csum_err_o), 0);
      chk("R6 three reads", burst_n, 24);
      chk("R6 retry restarts at 0", addr_log[8] + addr_log[16], 0);
      chk("R6 done flagged", int'(done_o), 1);
   endtask

   task automatic t_retry_fail();
      prep(3, 2);
      corrupt_left[0] = 3;
      run_fetch();
      chk("R7 csum flag", int'(csum_err_o), 1);
      chk("R7 no timeout", int'(timeout_o), 0);
      chk("R7 ext zero", int'(ext_count_o), 0);
      chk("R7 tries bounded", burst_n, 24);
   endtask

   task automatic t_timeout();
      prep(2, 2);
      hang_blk = 0;
      run_fetch();
      chk("R8 timeout flag", int'(timeout_o), 1);
      chk("R8 no csum flag", int'(csum_err_o), 0);
      chk("R8 ext zero", int'(ext_count_o), 0);
      chk("R8 single burst", burst_n, 1);
   endtask

   task automatic t_slow();
      prep(1, 30);
      run_fetch();
      chk("R8 slow within ticks", int'(timeout_o), 0);
      chk("R8 slow ext count", int'(ext_count_o), 1);
   endtask

   task automatic t_ext_csum();
      prep(3, 2);
      corrupt_left[2] = 3;
      run_fetch();
      chk("R10 ext csum truncates", int'(ext_count_o), 1);
      chk("R10 no flags csum", int'(timeout_o) + int'(csum_err_o), 0);
      chk("R10 bursts", burst_n, 40);
   endtask

   task automatic t_ext_retry();
      prep(1, 2);
      corrupt_left[1] = 1;
      run_fetch();
      chk("R6 ext retry succeeds", int'(ext_count_o), 1);
      chk("R6 ext retry bursts", burst_n, 24);
   endtask

   task automatic t_ext_hang_hold();
      prep(3, 2);
      hang_blk = 3;
      run_fetch();
      chk("R10 ext hang truncates", int'(ext_count_o), 2);
      chk("R10 no timeout flag", int'(timeout_o), 0);
      repeat (50) @(negedge clk);
      chk("R11 done held", int'(done_o), 1);
      chk("R11 ext held", int'(ext_count_o), 2);
      chk("R1 no command after done", int'(cmd_valid_o), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      start_i   = 1'b0;
      rd_addr_i = '0;
      prep(0, 2);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_cap();
      t_ext_zero();
      t_retry_ok();
      t_retry_fail();
      t_timeout();
      t_slow();
      t_ext_csum();
      t_ext_retry();
      t_ext_hang_hold();
      summary();
      $finish;
   end

endmodule